// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a slave on a two-wire serial bus. It fronts a bank of eight byte registers that live outside the block. A master selects the slave with a START condition and the 7-bit device address 1101000. On a write, the first byte after the address loads an internal 3-bit register pointer, and each later byte is written to the register that the pointer selects. On a read, the slave shifts out the byte the pointer selects, most significant bit first. The slave drives the data line only low, through an open-drain enable.

The pointer steps forward by one after every written byte and after every read byte that the master acknowledges. It wraps from 7 to 0. A read that has no address phase of its own starts at whatever the pointer holds. This holds both after a repeated START and when no address was written at all. A synchronous power-fail input ends any transfer, clears the pointer, and makes the block deaf to the bus while it is asserted.

SCL and SDA are synchronised to the system clock, which must run at least 16 times faster than SCL. The register bank sees a pointer output, a write strobe with data, and a read strobe. The read data must be a combinational function of the pointer output, because it is captured in the same cycle as the read strobe.

Top module: `twsl_regport`

## Requirements
- R1: While and after reset, and before any bus traffic, sda_oe is 0, reg_addr is 0, and reg_wr and reg_rd are both 0.
- R2: After a START, the slave acknowledges an address byte whose upper seven bits are 1101000, by driving sda_oe high during the ninth clock. Bit 0 of that byte is the direction: 0 means write (byte D0h) and 1 means read (byte D1h).
- R3: An address byte with any other upper seven bits gets no acknowledge. The slave then ignores every following byte, writing nothing and leaving the pointer unchanged, until the next START.
- R4: In a write, the byte after the address is the word address. Its low 3 bits load the pointer, and the slave acknowledges it. The pointer keeps that value even if a STOP follows at once.
- R5: Each data byte in a write is acknowledged and written, through one reg_wr pulse with reg_addr equal to the pointer. The pointer then advances by one, wrapping from 7 to 0.
- R6: In a read, the slave sends the byte at reg_addr, most significant bit first. When the master acknowledges, the pointer advances and the next byte follows.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and the pointer does not advance.
- R8: A read entered through a repeated START, or with no address write before it, begins at the current pointer value.
- R9: While pwr_fail is 1, the transfer in progress ends, the pointer is 0 from the next cycle, sda_oe is 0, and no bus activity is acknowledged or written.
- R10: A STOP returns the slave to idle with SDA released. Bytes clocked after that without a new START are not acknowledged.
- R11: reg_wr and reg_rd are never high in the same cycle. Each write lasts one cycle, and each byte sent to the master produces exactly one reg_rd pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_fail | input | 1 | Power-fail indication, synchronous to clk; aborts and blocks bus access |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 3 | Register pointer presented to the register bank |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe; reg_rdata is captured in this cycle |
| reg_rdata | input | 8 | Read data for reg_addr, combinational |

## Verification
The hardest state to reach is a power failure in the middle of a write. It must land after the word address has been accepted but before the data byte completes. The bench builds this with a partial transaction: it sends the address, then the word address, then raises pwr_fail between bytes. While pwr_fail stays high it drives a complete write, then drops pwr_fail. A current-address read after that shows the pointer was cleared and nothing was stored. Pointer wrap and the no-advance rule on a master NACK are reached by sweeping every start address with transfers whose lengths cross the 7-to-0 boundary.

// File: rtl/twsl_pkg.sv
// Shared types for the two-wire slave register port.
package twsl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting a byte in from the master
        ST_RXACK,  // slave acknowledge slot
        ST_TX,     // shifting a byte out to the master
        ST_TXACK   // master acknowledge slot
    } twsl_state_e;

    typedef enum logic [1:0] {
        RK_DEV,    // device address byte
        RK_WORD,   // word address byte
        RK_DATA    // data byte
    } twsl_rxkind_e;
endpackage

// File: rtl/twsl_sync.sv
// Synchroniser and event detector for the two bus lines.
// Assumes: the lines are asynchronous to clk and idle high; STAGES >= 2.
// Produces clean levels plus one-cycle SCL edges and START/STOP events.
module twsl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_lvl;

    // Purpose: metastability chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twsl_ptr.sv
// Register pointer: clear, load and increment with wrap-around.
// Assumes: clear has priority over load, and load has priority over increment.
module twsl_ptr #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    // Purpose: hold the pointer, modulo 2**AW.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (clr)  ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + AW'(1);
    end

    // R9
    ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0));
endmodule

// File: rtl/twsl_engine.sv
// Byte-level protocol engine of the slave.
// Assumes: inputs come from twsl_sync; reg_rdata is combinational from the
// pointer; pwr_fail is synchronous and overrides all bus events.
module twsl_engine
    import twsl_pkg::*;
#(
    parameter int          AW       = 3,
    parameter logic [6:0]  DEV_ADDR = 7'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              ptr_load,
    output logic [AW-1:0]     ptr_load_val,
    output logic              ptr_inc
);
    localparam int CW = $clog2(BYTE_W + 1);

    twsl_state_e       state;
    twsl_rxkind_e      rx_kind;
    logic [CW-1:0]     bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw_bit;
    logic              mack;
    logic              go;
    logic              byte_done;

    // Purpose: qualify bus events when no abort or framing event is present.
    assign go        = ~pwr_fail & ~start_det & ~stop_det;
    assign byte_done = (bitcnt == CW'(BYTE_W));

    // Purpose: decide when a byte is fetched for the master.
    assign reg_rd = go & scl_fall &
                    (((state == ST_RXACK) & (rx_kind == RK_DEV) & rw_bit) |
                     ((state == ST_TXACK) & mack));

    // Purpose: pointer load on the word address, advance on write or master ACK.
    assign ptr_load     = go & scl_fall & (state == ST_RX) &
                          (rx_kind == RK_WORD) & byte_done;
    assign ptr_load_val = shreg[AW-1:0];
    assign ptr_inc      = reg_wr | (go & scl_rise & (state == ST_TXACK) & ~sda_lvl);

    // Purpose: protocol state, shift register, SDA drive and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rx_kind   <= RK_DEV;
            bitcnt    <= '0;
            shreg     <= '0;
            rw_bit    <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr <= 1'b0;
            if (pwr_fail) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state   <= ST_RX;
                rx_kind <= RK_DEV;
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && !byte_done) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + CW'(1);
                        end else if (scl_fall && byte_done) begin
                            if (rx_kind == RK_DEV) begin
                                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                    rw_bit <= shreg[0];
                                    state  <= ST_RXACK;
                                    sda_oe <= 1'b1;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                if (rx_kind == RK_DATA) reg_wdata <= shreg;
                                state  <= ST_RXACK;
                                sda_oe <= 1'b1;
                            end
                        end
                    end
                    ST_RXACK: begin
                        if (scl_rise && rx_kind == RK_DATA) begin
                            reg_wr <= 1'b1;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (rx_kind == RK_DEV && rw_bit) begin
                                state  <= ST_TX;
                                shreg  <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                            end else begin
                                state   <= ST_RX;
                                sda_oe  <= 1'b0;
                                rx_kind <= (rx_kind == RK_DEV) ? RK_WORD : RK_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == CW'(BYTE_W - 1)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TXACK;
                            end else begin
                                bitcnt <= bitcnt + CW'(1);
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack) begin
                                state  <= ST_TX;
                                bitcnt <= '0;
                                shreg  <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd, reg_wr}));

    // R11
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R10
    stop_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_oe && !reg_wr));
endmodule

// File: rtl/twsl_regport.sv
// Top of the two-wire slave register port.
// Assumes: clk is at least 16x the SCL rate; the register bank answers
// reg_rdata combinationally from reg_addr and stores reg_wdata on reg_wr.
module twsl_regport
    import twsl_pkg::*;
#(
    parameter int         AW          = 3,
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [AW-1:0]     reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic          sda_lvl;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          ptr_load;
    logic [AW-1:0] ptr_load_val;
    logic          ptr_inc;

    twsl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twsl_engine #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_fail     (pwr_fail),
        .sda_lvl      (sda_lvl),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .reg_rdata    (reg_rdata),
        .sda_oe       (sda_oe),
        .reg_rd       (reg_rd),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_inc      (ptr_inc)
    );

    twsl_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pwr_fail),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .inc      (ptr_inc),
        .ptr      (reg_addr)
    );

    // R5
    wr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_fail)
        reg_wr |=> (reg_addr == $past(reg_addr) + AW'(1)));

    // R9
    pf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (!sda_oe && !reg_wr));
endmodule

// File: tb/twsl_regport_bench.sv
// Self-checking bench: bus master model plus a register bank model.
module twsl_regport_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [2:0] reg_addr;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] rf [8];
    logic [7:0] exp_mem [8];
    int         exp_ptr = 0;
    int         vectors = 0;
    int         fails = 0;
    int         bad_strobe = 0;
    int         wr_cnt = 0;
    int         rd_cnt = 0;
    int         exp_wr = 0;
    int         exp_rd = 0;
    logic       wr_prev = 1'b0;

    always #5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = rf[reg_addr];

    twsl_regport u_twsl_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_fail  (pwr_fail),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    // Register bank model.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) rf[i] <= 8'h10 + 8'(i * 7);
        end else if (reg_wr) begin
            rf[reg_addr] <= reg_wdata;
        end
    end

    // Strobe monitor for R11.
    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_wr && reg_rd) bad_strobe++;
            if (reg_wr && wr_prev) bad_strobe++;
            if (reg_wr) wr_cnt++;
            if (reg_rd) rd_cnt++;
            wr_prev <= reg_wr;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output int ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2 * Q);
            scl_m = 1'b0; wq(2);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = sda_line ? 0 : 1;
        wq(Q);
        scl_m = 1'b0; wq(2);
    endtask

    task automatic recv_byte(input bit give_ack, output int b);
        logic [7:0] v;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            v[i] = sda_line;
            wq(Q);
            scl_m = 1'b0;
        end
        wq(2);
        sda_m = give_ack ? 1'b0 : 1'b1; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(2);
        sda_m = 1'b1;
        b = int'(v);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < 8; i++) chk(req, int'(rf[i]), int'(exp_mem[i]));
    endtask

    task automatic write_txn(input int a, input int n);
        int ack;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD0, ack); chk("R2 write address ack", ack, 1);
        send_byte(8'(a), ack); chk("R4 word address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'(a * 29 + k * 11 + 3);
            send_byte(d, ack); chk("R5 data ack", ack, 1);
            exp_mem[(a + k) % 8] = d;
            exp_wr++;
        end
        bus_stop;
        exp_ptr = (a + n) % 8;
        wq(4);
        chk("R5 pointer after write (wrap)", int'(reg_addr), exp_ptr);
        check_bank("R5 stored byte");
    endtask

    task automatic read_txn(input int a, input int n);
        int ack;
        int b;
        bus_start;
        send_byte(8'hD0, ack); chk("R2 write address ack", ack, 1);
        send_byte(8'(a), ack); chk("R4 word address ack", ack, 1);
        bus_start;
        send_byte(8'hD1, ack); chk("R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk("R6 R8 read byte", b, int'(exp_mem[(a + k) % 8]));
            exp_rd++;
        end
        chk("R7 SDA released after NACK", int'(sda_oe), 0);
        bus_stop;
        exp_ptr = (a + n - 1) % 8;
        wq(4);
        chk("R7 pointer holds at NACKed byte", int'(reg_addr), exp_ptr);
    endtask

    task automatic current_read(input string req);
        int ack;
        int b;
        bus_start;
        send_byte(8'hD1, ack); chk("R2 read address ack", ack, 1);
        recv_byte(1'b0, b);
        chk(req, b, int'(exp_mem[exp_ptr]));
        exp_rd++;
        bus_stop;
        wq(4);
        chk("R7 pointer after current read", int'(reg_addr), exp_ptr);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_mem[i] = 8'h10 + 8'(i * 7);
        wq(5);
        // R1: reset state
        chk("R1 sda_oe in reset", int'(sda_oe), 0);
        chk("R1 reg_addr in reset", int'(reg_addr), 0);
        chk("R1 strobes in reset", int'({reg_wr, reg_rd}), 0);
        rst_n = 1'b1;
        wq(Q);
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        chk("R1 reg_addr after reset", int'(reg_addr), 0);

        // R8: read with no prior pointer write
        current_read("R8 read without address write");

        // R2 R4 R5: write sweep over every start address
        for (int a = 0; a < 8; a++) write_txn(a, 3);

        // R6 R7 R8: read sweep with varying lengths
        for (int a = 0; a < 8; a++) read_txn(a, (a % 4) + 2);
        current_read("R8 current address read");

        // R3: non-matching device addresses
        begin
            logic [7:0] bad [3];
            int ack;
            bad[0] = 8'hA0; bad[1] = 8'hD2; bad[2] = 8'h50;
            for (int j = 0; j < 3; j++) begin
                bus_start;
                send_byte(bad[j], ack); chk("R3 no ack on foreign address", ack, 0);
                send_byte(8'h02, ack);  chk("R3 following byte ignored", ack, 0);
                send_byte(8'hEE, ack);  chk("R3 following byte ignored", ack, 0);
                bus_stop;
                wq(4);
                chk("R3 pointer untouched", int'(reg_addr), exp_ptr);
            end
            check_bank("R3 bank untouched");
        end

        // R4 R10: word address then STOP, then a byte without START
        begin
            int ack;
            bus_start;
            send_byte(8'hD0, ack); chk("R2 write address ack", ack, 1);
            send_byte(8'h04, ack); chk("R4 word address ack", ack, 1);
            bus_stop;
            wq(4);
            exp_ptr = 4;
            chk("R4 pointer loaded by word address", int'(reg_addr), 4);
            chk("R10 SDA released after STOP", int'(sda_oe), 0);
            scl_m = 1'b0; wq(Q);
            send_byte(8'h55, ack); chk("R10 no ack without START", ack, 0);
            bus_stop;
            wq(4);
            check_bank("R10 bank untouched");
        end

        // R9: power fail in the middle of a write
        begin
            int ack;
            bus_start;
            send_byte(8'hD0, ack); chk("R2 write address ack", ack, 1);
            send_byte(8'h06, ack); chk("R4 word address ack", ack, 1);
            pwr_fail = 1'b1;
            wq(3);
            chk("R9 pointer cleared", int'(reg_addr), 0);
            chk("R9 SDA released", int'(sda_oe), 0);
            send_byte(8'h3C, ack); chk("R9 data ignored", ack, 0);
            bus_stop;
            bus_start;
            send_byte(8'hD0, ack); chk("R9 address ignored", ack, 0);
            send_byte(8'h02, ack); chk("R9 word ignored", ack, 0);
            send_byte(8'h77, ack); chk("R9 data ignored", ack, 0);
            bus_stop;
            chk("R9 pointer held at zero", int'(reg_addr), 0);
            pwr_fail = 1'b0;
            wq(Q);
            exp_ptr = 0;
            check_bank("R9 bank untouched");
            current_read("R9 read after power fail starts at 0");
        end

        // R11: strobe discipline
        chk("R11 strobe overlap or stretch", bad_strobe, 0);
        chk("R11 write strobe count", wr_cnt, exp_wr);
        chk("R11 read strobe count", rd_cnt, exp_rd);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule